// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external 64K x 8 asynchronous static RAM. A user issues one request at a time (address, write data and a write flag) and receives a one-cycle `ready` pulse when the access has finished. For reads, the returned byte appears on `rdata` along with that pulse.

On the memory side the controller drives a 16-bit address, an active-low and an active-high chip select, an active-low output enable and an active-low write enable. It also drives the data bus through separate output, output-enable and input ports, so the tristate pad sits at the chip top. The strobe widths and recovery gaps are whole numbers of clock cycles. They are derived from a clock-period parameter and a speed-grade parameter (0 selects the 55 ns grade, 1 the 70 ns grade) by rounding each nanosecond limit up.

The state machine has four states:

- **IDLE**: both selects are inactive and all strobes are high.
- **SETUP**: the selects are active, the address is valid, and write data is driven on writes only.
- **STROBE**: write enable is low for a write, or output enable is low for a read.
- **RECOVER**: the strobes are released while address and write data are held.

It has four transitions:

- **accept** moves IDLE to SETUP when `req` is high.
- **fire** moves SETUP to STROBE when the setup count expires.
- **release** moves STROBE to RECOVER when the strobe count expires.
- **finish** moves RECOVER to IDLE when the recovery count expires and raises `ready`.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, with no request pending, `sram_cs_n`=1, `sram_cs`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0 and `ready`=0.
- R2: From the cycle after a request is accepted until the transaction's last recovery cycle, `sram_cs_n`=0 and `sram_cs`=1. Outside that span the selects are inactive. A strobe is never low while the selects are inactive.
- R3: Writes use one setup cycle, then `sram_we_n` low for ceil(max(write pulse, select-to-end, address-to-end, data overlap)/period) cycles. That is 12 cycles at the 55 ns grade with a 4 ns clock, using limits of 40/45/45/25 ns (50/60/60/30 ns for the 70 ns grade). `sram_dq_oe` is 1 and `sram_dq_o` is stable from setup through recovery.
- R4: Reads use one setup cycle with the bus released, then `sram_oe_n` low for ceil(max(access, output-enable access)/period) cycles. That is 14 cycles at 55/25 ns (70/35 ns for the slow grade). `rdata` takes `sram_dq_i` at the clock edge that ends the strobe.
- R5: After a read strobe the controller leaves the bus undriven for at least ceil(output-disable time/period) recovery cycles: 5 cycles at 20 ns (25 ns for the slow grade).
- R6: Each transaction spans at least ceil(cycle time/period) cycles from SETUP to the end of RECOVER. Write recovery is max(1, that minus setup and strobe), giving 14 cycles in total for a write and 20 for a read at the default parameters.
- R7: `ready` is high for exactly one cycle, the first IDLE cycle after RECOVER. For reads, `rdata` holds the read byte then.
- R8: A request is accepted only in IDLE. Asserting `req` while a transaction is in progress has no effect on the memory or on the sequence of that transaction.
- R9: `sram_we_n` and `sram_oe_n` are never low together. `sram_addr` stays constant from SETUP through RECOVER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken in IDLE |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data |
| sram_addr | output | 16 | Memory address |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_o | output | 8 | Data driven to the memory |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_i | input | 8 | Data returned by the memory |

## Verification
All outputs follow a request accepted at clock edge e:

- The selects go active one cycle after e.
- The strobe falls after 1 + setup cycles.
- `ready` rises 14 cycles after e for a write and 20 cycles after e for a read.

The bench's reference model counts the cycles since each acceptance and predicts every memory-side output for each cycle; it compares them at the falling edge, away from the edge that updates them. The bench's memory model returns valid data only after output enable and the address have been stable for the full access time, so read data is meaningful only at the end of the strobe. The reported read byte and the request-to-ready latency are checked at the falling edge where `ready` is first seen.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER
    } sram_state_e;

    function automatic int ceil_cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Setup is a single cycle: address valid, bus released or write data driven
    function automatic int setup_cycles();
        return 1;
    endfunction

    function automatic int wr_strobe_cycles(input int grade, input int per);
        int pulse_ns, sel_end_ns, adr_end_ns, ovl_ns;
        pulse_ns   = (grade != 0) ? 50 : 40;
        sel_end_ns = (grade != 0) ? 60 : 45;
        adr_end_ns = (grade != 0) ? 60 : 45;
        ovl_ns     = (grade != 0) ? 30 : 25;
        return imax(1, ceil_cyc(imax(imax(pulse_ns, sel_end_ns), imax(adr_end_ns, ovl_ns)), per));
    endfunction

    function automatic int rd_strobe_cycles(input int grade, input int per);
        int acc_ns, oe_ns;
        acc_ns = (grade != 0) ? 70 : 55;
        oe_ns  = (grade != 0) ? 35 : 25;
        return imax(1, ceil_cyc(imax(acc_ns, oe_ns), per));
    endfunction

    function automatic int wr_recover_cycles(input int grade, input int per);
        int cyc_ns;
        cyc_ns = (grade != 0) ? 70 : 55;
        return imax(1, ceil_cyc(cyc_ns, per) - setup_cycles() - wr_strobe_cycles(grade, per));
    endfunction

    function automatic int rd_recover_cycles(input int grade, input int per);
        int cyc_ns, float_ns;
        cyc_ns   = (grade != 0) ? 70 : 55;
        float_ns = (grade != 0) ? 25 : 20;
        return imax(imax(1, ceil_cyc(float_ns, per)),
                    ceil_cyc(cyc_ns, per) - setup_cycles() - rd_strobe_cycles(grade, per));
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= in_wr;
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_in;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_cs,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int SETUP_CYC = setup_cycles();
    localparam int WR_STB    = wr_strobe_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int RD_STB    = rd_strobe_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int WR_REC    = wr_recover_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int RD_REC    = rd_recover_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int CNT_MAX   = imax(imax(WR_STB, RD_STB), imax(WR_REC, RD_REC));
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    sram_state_e      state_q, state_d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             last;
    logic             wr_q;
    logic             accept;
    logic             capture;
    logic             ready_q;

    assign accept  = (state_q == ST_IDLE) && req;
    assign capture = (state_q == ST_STROBE) && last && !wr_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .last     (last)
    );

    sram_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .in_wr    (req_wr),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .dq_in    (sram_dq_i),
        .wr_q     (wr_q),
        .addr_q   (sram_addr),
        .wdata_q  (sram_dq_o),
        .rdata_q  (rdata)
    );

    // Transition logic: accept, fire, release, finish
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_SETUP;
                    ld      = 1'b1;
                    ld_val  = CNT_W'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (last) begin
                    state_d = ST_STROBE;
                    ld      = 1'b1;
                    ld_val  = wr_q ? CNT_W'(WR_STB - 1) : CNT_W'(RD_STB - 1);
                end
            end
            ST_STROBE: begin
                if (last) begin
                    state_d = ST_RECOVER;
                    ld      = 1'b1;
                    ld_val  = wr_q ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
                end
            end
            ST_RECOVER: begin
                if (last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= (state_q == ST_RECOVER) && last;
        end
    end

    assign ready = ready_q;

    // Memory-side control decode
    always_comb begin
        sram_cs_n  = 1'b1;
        sram_cs    = 1'b0;
        sram_oe_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SETUP: begin
                sram_cs_n  = 1'b0;
                sram_cs    = 1'b1;
                sram_dq_oe = wr_q;
            end
            ST_STROBE: begin
                sram_cs_n  = 1'b0;
                sram_cs    = 1'b1;
                sram_we_n  = !wr_q;
                sram_oe_n  = wr_q;
                sram_dq_oe = wr_q;
            end
            ST_RECOVER: begin
                sram_cs_n  = 1'b0;
                sram_cs    = 1'b1;
                sram_dq_oe = wr_q;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_cs,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [DATA_W-1:0] sram_dq_o,
    input logic              sram_dq_oe
);
    localparam int WR_STB = wr_strobe_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int RD_STB = rd_strobe_cycles(SPEED_GRADE, CLK_PERIOD_NS);

    logic [15:0] we_low_cnt, oe_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= sram_we_n ? 16'd0 : we_low_cnt + 16'd1;
            oe_low_cnt <= sram_oe_n ? 16'd0 : oe_low_cnt + 16'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe));

    assert_strobe_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || !sram_oe_n) |-> (!sram_cs_n && sram_cs));

    assert_write_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_cs_n && sram_dq_oe));

    assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt == 16'(WR_STB)));

    assert_wdata_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

    assert_read_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> $past(!sram_cs_n && !sram_dq_oe));

    assert_read_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_low_cnt == 16'(RD_STB)));

    assert_no_drive_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> !sram_dq_oe);

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> sram_cs_n);

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .SPEED_GRADE   (SPEED_GRADE),
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .sram_addr  (sram_addr),
    .sram_cs_n  (sram_cs_n),
    .sram_cs    (sram_cs),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
    localparam int PER = 4;

    function automatic int cdiv(input int ns);
        return (ns + PER - 1) / PER;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int B_SET  = 1;
    localparam int B_WSTB = 12;   // ceil(45/4)
    localparam int B_RSTB = 14;   // ceil(55/4)
    localparam int B_WREC = 1;    // max(1, 14-1-12)
    localparam int B_RREC = 5;    // ceil(20/4)
    localparam int B_OE   = 7;    // ceil(25/4)
    localparam int B_AA   = 14;   // ceil(55/4)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic [15:0] sram_addr;
    logic        sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_o;
    logic [7:0]  sram_dq_i = 8'hEE;

    always #2 clk = ~clk;

    sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_cs(sram_cs), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [7:0] dflt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h96;
    endfunction

    // Memory model on the device side
    logic [7:0]  sram_mem [int];
    logic [7:0]  exp_mem  [int];
    logic        prev_we = 1'b1;
    logic [15:0] prev_addr = '0;
    int          oe_cnt = 0, a_cnt = 0;

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        return sram_mem.exists(int'(a)) ? sram_mem[int'(a)] : dflt(a);
    endfunction
    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            oe_cnt = 0; a_cnt = 0; prev_we = 1'b1; prev_addr = '0; sram_dq_i = 8'hEE;
        end else begin
            if (!prev_we && sram_we_n) sram_mem[int'(sram_addr)] = sram_dq_o;
            prev_we = sram_we_n;
            oe_cnt = (!sram_oe_n && !sram_cs_n && sram_cs) ? oe_cnt + 1 : 0;
            a_cnt  = (sram_addr == prev_addr) ? a_cnt + 1 : 0;
            prev_addr = sram_addr;
            sram_dq_i = (oe_cnt >= B_OE && a_cnt >= B_AA) ? mem_rd(sram_addr) : 8'hEE;
        end
    end

    // Cycle reference model: advances on the rising edge
    bit          m_busy = 0, m_wr = 0, m_ready = 0;
    int          m_t = 0, m_tot = 0, m_stb = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_ready = 0;
        end else begin
            m_ready = 0;
            if (m_busy) begin
                if (m_t == m_tot) begin m_busy = 0; m_ready = 1; end
                else m_t++;
            end else if (req) begin
                m_busy = 1; m_t = 1; m_wr = req_wr; m_addr = req_addr; m_wd = req_wdata;
                m_stb = req_wr ? B_WSTB : B_RSTB;
                m_tot = B_SET + m_stb + (req_wr ? B_WREC : B_RREC);
            end
        end
    end

    // Compare every cycle at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit strobe;
            strobe = m_busy && (m_t > B_SET) && (m_t <= B_SET + m_stb);
            chk((sram_cs_n == !m_busy) && (sram_cs == m_busy), "R2 selects",
                {sram_cs_n, sram_cs}, {!m_busy, m_busy});
            chk(sram_we_n == !(strobe && m_wr), "R3 we_n", sram_we_n, !(strobe && m_wr));
            chk(sram_oe_n == !(strobe && !m_wr), "R4 oe_n", sram_oe_n, !(strobe && !m_wr));
            chk(sram_dq_oe == (m_busy && m_wr), "R5 bus drive", sram_dq_oe, m_busy && m_wr);
            chk(ready == m_ready, "R7 ready", ready, m_ready);
            if (m_busy) begin
                chk(sram_addr == m_addr, "R9 address", sram_addr, m_addr);
                if (m_wr) chk(sram_dq_o == m_wd, "R3 write data", sram_dq_o, m_wd);
            end
        end
    end

    task automatic do_txn(input bit wr, input logic [15:0] a, input logic [7:0] d);
        int lat;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        if (wr) exp_mem[int'(a)] = d;
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!ready && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == (wr ? B_SET + B_WSTB + B_WREC : B_SET + B_RSTB + B_RREC),
            "R6 latency", lat, wr ? B_SET + B_WSTB + B_WREC : B_SET + B_RSTB + B_RREC);
        if (!wr) chk(rdata == exp_rd(a), "R4 read data", rdata, exp_rd(a));
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(sram_cs_n && !sram_cs && sram_we_n && sram_oe_n && !sram_dq_oe && !ready,
            "R1 reset state", {sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe, ready}, 6'b101100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sram_cs_n && !sram_cs && sram_we_n && sram_oe_n && !sram_dq_oe && !ready,
            "R1 idle state", {sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe, ready}, 6'b101100);

        do_txn(1'b1, 16'h0000, 8'h5A);
        do_txn(1'b1, 16'hFFFF, 8'hA5);
        do_txn(1'b1, 16'h1234, 8'h3C);
        do_txn(1'b0, 16'h0000, 8'h00);
        do_txn(1'b0, 16'hFFFF, 8'h00);
        do_txn(1'b0, 16'h1234, 8'h00);
        do_txn(1'b0, 16'h0042, 8'h00);

        // R8: a request raised mid-transaction is ignored
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 16'h2222; req_wdata = 8'h11;
        exp_mem[int'(16'h2222)] = 8'h11;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 16'h0BAD; req_wdata = 8'hEE;
        repeat (3) @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        chk(!sram_mem.exists(int'(16'h0BAD)), "R8 ignored request", sram_mem.exists(int'(16'h0BAD)), 0);
        do_txn(1'b0, 16'h0BAD, 8'h00);
        do_txn(1'b0, 16'h2222, 8'h00);

        do_txn(1'b1, 16'h1234, 8'hC3);
        do_txn(1'b0, 16'h1234, 8'h00);
        do_txn(1'b1, 16'h8001, 8'hFF);
        do_txn(1'b0, 16'h8001, 8'h00);

        repeat (3) @(negedge clk);
        chk(sram_cs_n && !sram_dq_oe && !ready, "R1 idle after traffic",
            {sram_cs_n, sram_dq_oe, ready}, 3'b100);
        finish_run();
    end
endmodule